// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns the two phase signals and the index pulse of an incremental rotary or linear encoder into a 32-bit position count. Each input goes through a two-stage synchronizer and an optional glitch filter. A decoder then compares the filtered phase pair with its previous value and reports a step up, a step down, no step, or an illegal double change. The count moves by one on every edge of either phase, so the resolution is four counts per encoder line.

The count can work in one of two ways. In ceiling mode it wraps between zero and a programmable ceiling. In index mode it returns to zero on an index pulse, but only when that pulse arrives in one chosen state of the phase pair. The block also reports the last direction of travel. Events are recorded in sticky status flags that are cleared by writing 1, and each flag has a mask bit. The interrupt line is the registered OR of all unmasked flags.

Configuration arrives through plain write-strobe ports. While the counter runs, the configuration is frozen except for the run bit itself.

Top module: `quad_pos_counter`

## Requirements
- R1: While running, each change of exactly one filtered phase moves the count by one. The phase pair {A,B} counts up along 00→10→11→01→00 and counts down along the reverse of that sequence.
- R2: Control bit 5 exchanges the A and B inputs, so the same physical motion counts in the opposite direction.
- R3: When A and B both change in the same clock cycle, the count does not change and control bit 7 is set. Bit 7 stays set until a control write with bit 7 set clears it.
- R4: With control bit 8 clear (ceiling mode), stepping up from the ceiling gives 0 and sets status bit 2. Stepping down from 0 loads the ceiling and sets status bit 1.
- R5: While control bit 0 (run) is set, a ceiling write is ignored and a control write changes only bit 0.
- R6: With control bit 8 set (index mode), a rising index edge clears the count when the phase pair {A,B} equals control bits 10:9 (0=A low B low, 1=A low B high, 2=A high B low, 3=A high B high). The clear sets status bit 2 if the last direction was up and status bit 1 if it was down. An index edge in any other phase state is ignored. The ceiling does not apply in index mode.
- R7: Output dir_up follows the direction of the last step. A step whose direction differs from dir_up sets status bit 3.
- R8: Status flags are sticky, and a write of 1 to a bit clears it. Bits 0, 4 and 5 always read 0. The mask resets to all ones (1 = masked). irq is the registered OR of the unmasked status bits.
- R9: While run is clear, phase and index activity leave the count and status unchanged.
- R10: Control bit 1 enables the filter. With the filter on, a phase change must persist for FILT_LEN clock cycles before the decoder sees it, so shorter pulses are dropped.
- R11: After reset the count is 0, dir_up is 1, control and status are 0, the mask is all ones and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Raw phase A |
| enc_b | input | 1 | Raw phase B |
| enc_idx | input | 1 | Raw index pulse |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control write data |
| ceil_we | input | 1 | Ceiling write strobe |
| ceil_wdata | input | CNT_W | Ceiling write data |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 6 | Mask write data |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | 6 | Status bits to clear |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Last step direction, 1 = up |
| ctl_q | output | 16 | Control word readback, including the phase-error bit |
| status | output | 6 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
A table drives a full forward cycle of the phase pair through the ceiling. It then reverses through zero, turns back up, and ends on a simultaneous change of both phases. This separates a correct up/down decode from a mirrored one, shows that wraps at both ends land on the right value, and proves that an illegal double change is flagged but not counted. Directed runs then check four things. Inputs are swapped when A and B differ, so a swap error shows up as a wrong direction. Index pulses are sent in the gated phase state and in a different one, which exposes a gate-compare error. A filtered glitch is sent just shorter than a legal edge, which separates rejection from acceptance. Writes made while running show which registers are frozen.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int CTL_W       = 16;
  localparam int CTL_RUN     = 0;
  localparam int CTL_FILT    = 1;
  localparam int CTL_SWAP    = 5;
  localparam int CTL_PERR    = 7;
  localparam int CTL_IDXMODE = 8;
  localparam int CTL_GATE_LO = 9;
  localparam logic [CTL_W-1:0] CTL_WR_MASK = 16'h0723;

  localparam int ST_W     = 6;
  localparam int ST_DNRST = 1;
  localparam int ST_UPRST = 2;
  localparam int ST_DIRCH = 3;
  localparam logic [ST_W-1:0] ST_IMPL = 6'b001110;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_ERR  = 2'd3
  } step_e;
endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic flt_en,
  input  logic raw,
  output logic q
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      q   <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (!flt_en) begin
        q   <= s2;
        cnt <= '0;
      end else if (s2 == q) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        q   <= s2;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: with filtering on, an input that agrees with the output cannot move it
  p_filter_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (flt_en && s2 == q) |=> $stable(q));
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a,
  input  logic       b,
  input  logic       swap,
  output logic [1:0] cur_ab,
  output step_e      step
);
  logic [1:0] prev_ab;

  assign cur_ab = swap ? {b, a} : {a, b};

  always_ff @(posedge clk) begin
    if (rst) prev_ab <= 2'b00;
    else     prev_ab <= cur_ab;
  end

  always_comb begin
    step = STEP_NONE;
    case ({prev_ab, cur_ab})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step = STEP_UP;
      4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: step = STEP_DN;
      4'b00_11, 4'b11_00, 4'b01_10, 4'b10_01: step = STEP_ERR;
      default:                                step = STEP_NONE;
    endcase
  end
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int                CNT_W    = 32,
  parameter logic [CNT_W-1:0]  CEIL_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  input  logic [1:0]       cur_ab,
  input  logic             idx,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ceil_we,
  input  logic [CNT_W-1:0] ceil_wdata,
  input  logic             mask_we,
  input  logic [ST_W-1:0]  mask_wdata,
  input  logic             clr_we,
  input  logic [ST_W-1:0]  clr_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  logic [CNT_W-1:0] ceil_q;
  logic [ST_W-1:0]  mask_q;
  logic             idx_q;
  logic             run, idx_mode, idx_rise, idx_hit;
  logic [1:0]       gate;
  logic [ST_W-1:0]  st_set, st_clr;
  logic [CTL_W-1:0] ctl_nxt;

  assign run      = ctl_q[CTL_RUN];
  assign idx_mode = ctl_q[CTL_IDXMODE];
  assign gate     = ctl_q[CTL_GATE_LO +: 2];
  assign idx_rise = idx && !idx_q;
  assign idx_hit  = run && idx_mode && idx_rise && (cur_ab == gate);

  always_comb begin
    ctl_nxt = ctl_q;
    if (ctl_we) begin
      if (run) ctl_nxt[CTL_RUN] = ctl_wdata[CTL_RUN];
      else     ctl_nxt = (ctl_wdata & CTL_WR_MASK) | (ctl_q & ~CTL_WR_MASK);
      if (ctl_wdata[CTL_PERR]) ctl_nxt[CTL_PERR] = 1'b0;
    end
    if (run && step == STEP_ERR) ctl_nxt[CTL_PERR] = 1'b1;
  end

  always_comb begin
    st_set = '0;
    if (idx_hit) begin
      st_set[dir_up ? ST_UPRST : ST_DNRST] = 1'b1;
    end else if (run && step == STEP_UP) begin
      if (!idx_mode && count == ceil_q) st_set[ST_UPRST] = 1'b1;
      if (!dir_up) st_set[ST_DIRCH] = 1'b1;
    end else if (run && step == STEP_DN) begin
      if (!idx_mode && count == '0) st_set[ST_DNRST] = 1'b1;
      if (dir_up) st_set[ST_DIRCH] = 1'b1;
    end
    st_clr = clr_we ? clr_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      ceil_q <= CEIL_RST;
      mask_q <= '1;
      idx_q  <= 1'b0;
      count  <= '0;
      dir_up <= 1'b1;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      ctl_q <= ctl_nxt;
      idx_q <= idx;
      if (ceil_we && !run) ceil_q <= ceil_wdata;
      if (mask_we) mask_q <= mask_wdata;
      if (idx_hit) begin
        count <= '0;
      end else if (run && step == STEP_UP) begin
        dir_up <= 1'b1;
        if (!idx_mode && count == ceil_q) count <= '0;
        else                              count <= count + 1'b1;
      end else if (run && step == STEP_DN) begin
        dir_up <= 1'b0;
        if (!idx_mode && count == '0) count <= ceil_q;
        else                          count <= count - 1'b1;
      end
      status <= ((status & ~st_clr) | st_set) & ST_IMPL;
      irq    <= |(status & ~mask_q);
    end
  end

  // R4: stepping up from the ceiling in ceiling mode gives zero and the up flag
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !idx_mode && step == STEP_UP && count == ceil_q) |=> (count == '0 && status[ST_UPRST]));
  // R4: stepping down from zero loads the ceiling and sets the down flag
  p_wrap_dn_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !idx_mode && step == STEP_DN && count == '0) |=> (count == $past(ceil_q) && status[ST_DNRST]));
  // R5: the ceiling is frozen while running
  p_ceil_lock_r5: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(ceil_q));
  // R3: a double change leaves the count alone and raises the error bit
  p_perr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run && step == STEP_ERR && !idx_hit) |=> ($stable(count) && ctl_q[CTL_PERR]));
  // R9: nothing moves the count while stopped
  p_stopped_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count));
  // R6: a gated index edge clears the count
  p_index_clear_r6: assert property (@(posedge clk) disable iff (rst)
    idx_hit |=> count == '0);
  // R8: a fully masked status cannot raise the interrupt
  p_masked_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int               CNT_W    = 32,
  parameter int               FILT_LEN = 8,
  parameter logic [CNT_W-1:0] CEIL_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  input  logic             ceil_we,
  input  logic [CNT_W-1:0] ceil_wdata,
  input  logic             mask_we,
  input  logic [5:0]       mask_wdata,
  input  logic             clr_we,
  input  logic [5:0]       clr_wdata,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic [15:0]      ctl_q,
  output logic [5:0]       status,
  output logic             irq
);
  localparam int NCH = 3;

  logic [NCH-1:0] raw_in, flt_out;
  logic [1:0]     cur_ab;
  step_e          step;

  assign raw_in = {enc_idx, enc_b, enc_a};

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    qpc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .flt_en (ctl_q[CTL_FILT]),
      .raw    (raw_in[g]),
      .q      (flt_out[g])
    );
  end

  qpc_decoder u_dec (
    .clk    (clk),
    .rst    (rst),
    .a      (flt_out[0]),
    .b      (flt_out[1]),
    .swap   (ctl_q[CTL_SWAP]),
    .cur_ab (cur_ab),
    .step   (step)
  );

  qpc_counter #(.CNT_W(CNT_W), .CEIL_RST(CEIL_RST)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .cur_ab     (cur_ab),
    .idx        (flt_out[2]),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .ceil_we    (ceil_we),
    .ceil_wdata (ceil_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_we     (clr_we),
    .clr_wdata  (clr_wdata),
    .ctl_q      (ctl_q),
    .count      (count),
    .dir_up     (dir_up),
    .status     (status),
    .irq        (irq)
  );
endmodule

// File: tb/quad_pos_counter_tb.sv
module quad_pos_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 0, enc_b = 0, enc_idx = 0;
  logic        ctl_we = 0, ceil_we = 0, mask_we = 0, clr_we = 0;
  logic [15:0] ctl_wdata = '0;
  logic [31:0] ceil_wdata = '0;
  logic [5:0]  mask_wdata = '0, clr_wdata = '0;
  logic [31:0] count;
  logic        dir_up, irq;
  logic [15:0] ctl_q;
  logic [5:0]  status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_pos_counter u_dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ceil_we(ceil_we), .ceil_wdata(ceil_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .count(count), .dir_up(dir_up), .ctl_q(ctl_q), .status(status), .irq(irq)
  );

  // {a, b, dir_up, count}
  localparam logic [34:0] VEC [13] = '{
    {1'b1, 1'b0, 1'b1, 32'd1},
    {1'b1, 1'b1, 1'b1, 32'd2},
    {1'b0, 1'b1, 1'b1, 32'd3},
    {1'b0, 1'b0, 1'b1, 32'd4},
    {1'b1, 1'b0, 1'b1, 32'd5},
    {1'b1, 1'b1, 1'b1, 32'd0},
    {1'b1, 1'b0, 1'b0, 32'd5},
    {1'b0, 1'b0, 1'b0, 32'd4},
    {1'b0, 1'b1, 1'b0, 32'd3},
    {1'b1, 1'b1, 1'b0, 32'd2},
    {1'b0, 1'b1, 1'b1, 32'd3},
    {1'b1, 1'b0, 1'b1, 32'd3},
    {1'b1, 1'b1, 1'b1, 32'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_ceil(input logic [31:0] d);
    @(negedge clk); ceil_we = 1; ceil_wdata = d;
    @(negedge clk); ceil_we = 0;
  endtask

  task automatic wr_mask(input logic [5:0] d);
    @(negedge clk); mask_we = 1; mask_wdata = d;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic clr_st(input logic [5:0] d);
    @(negedge clk); clr_we = 1; clr_wdata = d;
    @(negedge clk); clr_we = 0;
  endtask

  task automatic drive_ab(input logic a, input logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    wait_cyc(6);
  endtask

  task automatic pulse_idx();
    @(negedge clk); enc_idx = 1;
    wait_cyc(6);
    enc_idx = 0;
    wait_cyc(6);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst = 0;
    wait_cyc(2);
    // R11 reset state
    chk("R11 count", count, 0);
    chk("R11 dir_up", 32'(dir_up), 1);
    chk("R11 ctl", 32'(ctl_q), 0);
    chk("R11 status", 32'(status), 0);
    chk("R11 irq", 32'(irq), 0);

    wr_ceil(32'd5);
    wr_ctl(16'h0001);
    // R1 R4 R7 R3 vector walk
    for (int i = 0; i < 13; i++) begin
      drive_ab(VEC[i][34], VEC[i][33]);
      chk("R1 count", count, VEC[i][31:0]);
      chk("R7 dir_up", 32'(dir_up), 32'(VEC[i][32]));
    end
    chk("R4 R7 status", 32'(status), 32'h0E);
    chk("R3 perr bit", 32'(ctl_q[7]), 1);
    chk("R8 masked irq", 32'(irq), 0);
    wr_mask(6'h00);
    wait_cyc(3);
    chk("R8 unmasked irq", 32'(irq), 1);
    clr_st(6'h3F);
    wait_cyc(3);
    chk("R8 status cleared", 32'(status), 0);
    chk("R8 irq dropped", 32'(irq), 0);
    wr_ctl(16'h0081);
    wait_cyc(2);
    chk("R3 perr cleared", 32'(ctl_q[7]), 0);

    // R5: writes while running
    wr_ceil(32'd100);
    wr_ctl(16'h0121);
    wait_cyc(2);
    chk("R5 ctl frozen", 32'(ctl_q & 16'h0123), 32'h0001);
    drive_ab(1'b0, 1'b1);
    chk("R5 count", count, 5);
    drive_ab(1'b0, 1'b0);
    chk("R5 ceiling kept", count, 0);

    // R9: stopped
    wr_ctl(16'h0000);
    clr_st(6'h3F);
    drive_ab(1'b1, 1'b0);
    chk("R9 count held", count, 0);
    chk("R9 no flags", 32'(status), 0);

    // R2: swap while A and B differ, then move
    wr_ctl(16'h0021);
    drive_ab(1'b1, 1'b1);
    chk("R2 swapped down wrap", count, 5);
    chk("R2 dir down", 32'(dir_up), 0);

    // R6: index mode gated on A high B low
    wr_ctl(16'h0000);
    drive_ab(1'b1, 1'b0);
    wr_ctl(16'h0501);
    clr_st(6'h3F);
    pulse_idx();
    chk("R6 index clear", count, 0);
    chk("R6 down flag", 32'(status), 32'h02);
    drive_ab(1'b1, 1'b1);
    chk("R6 count up", count, 1);
    pulse_idx();
    chk("R6 gate mismatch ignored", count, 1);

    // R10: filter
    wr_ctl(16'h0000);
    wr_ctl(16'h0003);
    wait_cyc(4);
    @(negedge clk); enc_a = 0;
    wait_cyc(3);
    enc_a = 1;
    wait_cyc(20);
    chk("R10 glitch dropped", count, 1);
    @(negedge clk); enc_a = 0;
    wait_cyc(20);
    chk("R10 long edge counted", count, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule